// File: doc/BRIEF.md
# Multi-Mode Compare Timer with Carrier Output

This block is a 16-bit up-counting timer that software controls through a simple word-addressed register bus (address, write enable, write data, combinational read data). An 8-bit prescaler slows the input clock, and the counter advances once each time the prescaler wraps. The counter is compared against a programmable 16-bit value. Each match sets a timeout flag, which software clears by writing 1 to it, and it can raise an interrupt line.

Three counting modes are offered. The one-shot mode stops itself after the first match. The periodic mode returns the counter to zero after each match. The continuous mode flags the match but lets the counter run on through 0xFFFF. Any write to the control register or the compare register abandons the count in progress and starts again from zero. A reset bit in the control register stops the timer and clears its counters. A carrier pin can be made to toggle on every timeout, and it holds a programmable idle level while the carrier is switched off.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads 0, `irqOut` is 0 and `carrierOut` is 0.
- R2: Word registers sit at byte offsets 0x0 (control), 0x4 (compare), 0x8 (status), 0xC (count) and 0x10 (carrier). The control fields are: prescale [7:0], active [25], counter reset [26], mode [28:27], interrupt enable [29] and count enable [30]. Unused bits and unmapped offsets read 0.
- R3: With prescale P and compare C, the counter advances every P+1 clocks. The first match is flagged (C+1)*(P+1) clocks after the write that enables counting.
- R4: Mode 00 (one-shot) flags one match, then clears the count enable and returns the counter to 0.
- R5: Mode 01 (periodic) returns the counter to 0 on the tick after a match and flags each following match.
- R6: Mode 11 (continuous) flags the match, keeps counting past the compare value, and wraps from 0xFFFF to 0.
- R7: In mode 10 (reserved) the counter does not advance, and the active bit reads 0.
- R8: A write to the control or compare register clears the prescale counter and the counter, and counting restarts with the new values.
- R9: A control write with bit 26 set clears the counters and forces the count enable to 0. Bit 26 always reads 0.
- R10: The timeout flag is status bit 0. Writing 1 to it clears it, and writing 0 has no effect. If a clear and a match fall on the same cycle, the flag stays set.
- R11: `irqOut` is 1 exactly while the flag and the interrupt enable are both 1.
- R12: In the carrier register, bit 0 is the idle level and bit 1 is the enable. A write loads the toggle state with the idle level. While the carrier is enabled, each match toggles `carrierOut`. While it is disabled, `carrierOut` follows the idle level.
- R13: The count register and the active bit are read-only, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 5 | Byte address of the register access |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| irqOut | output | 1 | Timer interrupt |
| carrierOut | output | 1 | Carrier output pin |

## Verification
The assertions rely on software changing the mode only through a control write. Because every control write restarts the count, a periodic or one-shot counter never starts above its compare value. They also rely on the compare value never being lowered without a restart, since a compare write always restarts. The bench keeps to these assumptions: every configuration passes through the register bus, and it stops the timer before it reprograms anything. The bench also keeps the compare value at 3 or more, because values of 0 and 1 are outside the supported range.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int PSC_W  = 8;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_RSVD     = 2'b10,
    MODE_CONT     = 2'b11
  } tmrMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             restart;
    logic             run;
    logic             wrapZero;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] cmp;
  } dpStrobe_t;
endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [PSC_W-1:0] preCnt;
  logic             tick;

  assign tick = strb.run && (preCnt == strb.psc);
  assign hit  = tick && (cnt == strb.cmp) && !strb.restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
    end else if (strb.restart) begin
      preCnt <= '0;
      cnt    <= '0;
    end else if (strb.run) begin
      if (tick) begin
        preCnt <= '0;
        cnt    <= (hit && strb.wrapZero) ? '0 : cnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R8: restart empties the counter on the next cycle
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (cnt == '0));
  // R7: without run or restart the counter holds
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.restart) |=> $stable(cnt));
  // R5: in wrapping modes the count never passes the compare value
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrapZero |-> (cnt <= strb.cmp));
endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit,
  output dpStrobe_t         strb,
  output logic              irqOut,
  output logic              carrierOut
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int BIT_ACT   = 25;
  localparam int BIT_RST   = 26;
  localparam int BIT_MODE  = 27;
  localparam int BIT_INTEN = 29;
  localparam int BIT_EN    = 30;
  localparam int W_CTL = 0, W_CMP = 1, W_STS = 2, W_CNT = 3, W_CAR = 4;

  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cmp;
  tmrMode_e         mode;
  logic             intEn, cntEn, flag;
  logic             carIdle, carEn, carState;
  logic [IDX_W-1:0] wordIdx;
  logic             aligned, ctlWr, cmpWr, stsClr, carWr, run;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign ctlWr   = busWe && aligned && (int'(wordIdx) == W_CTL);
  assign cmpWr   = busWe && aligned && (int'(wordIdx) == W_CMP);
  assign stsClr  = busWe && aligned && (int'(wordIdx) == W_STS) && busWdata[0];
  assign carWr   = busWe && aligned && (int'(wordIdx) == W_CAR);
  assign run     = cntEn && (mode != MODE_RSVD);

  assign strb.restart  = ctlWr || cmpWr;
  assign strb.run      = run;
  assign strb.wrapZero = (mode != MODE_CONT);
  assign strb.psc      = psc;
  assign strb.cmp      = cmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psc   <= '0;
      cmp   <= '0;
      mode  <= MODE_ONESHOT;
      intEn <= 1'b0;
      cntEn <= 1'b0;
    end else begin
      if (ctlWr) begin
        psc   <= busWdata[PSC_W-1:0];
        mode  <= tmrMode_e'(busWdata[BIT_MODE +: 2]);
        intEn <= busWdata[BIT_INTEN];
        cntEn <= busWdata[BIT_EN] && !busWdata[BIT_RST];
      end else if (hit && mode == MODE_ONESHOT) begin
        cntEn <= 1'b0;
      end
      if (cmpWr) cmp <= busWdata[CNT_W-1:0];
    end
  end

  // timeout flag: a new match wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flag <= 1'b0;
    else if (hit)    flag <= 1'b1;
    else if (stsClr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carIdle  <= 1'b0;
      carEn    <= 1'b0;
      carState <= 1'b0;
    end else if (carWr) begin
      carIdle  <= busWdata[0];
      carEn    <= busWdata[1];
      carState <= busWdata[0];
    end else if (hit && carEn) begin
      carState <= !carState;
    end
  end

  assign irqOut     = flag && intEn;
  assign carrierOut = carEn ? carState : carIdle;

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      case (int'(wordIdx))
        W_CTL: begin
          busRdata[PSC_W-1:0]     = psc;
          busRdata[BIT_ACT]       = run;
          busRdata[BIT_MODE +: 2] = mode;
          busRdata[BIT_INTEN]     = intEn;
          busRdata[BIT_EN]        = cntEn;
        end
        W_CMP:   busRdata[CNT_W-1:0] = cmp;
        W_STS:   busRdata[0] = flag;
        W_CNT:   busRdata[CNT_W-1:0] = cnt;
        W_CAR:   busRdata[1:0] = {carEn, carIdle};
        default: busRdata = '0;
      endcase
    end
  end

  // R4: one-shot match without a concurrent control write stops counting
  a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rstN)
    (hit && mode == MODE_ONESHOT && !ctlWr) |=> !cntEn);
  // R10: a match always leaves the flag set
  a_r10_flag_sets: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> flag);
  // R10: a clear with no match empties the flag
  a_r10_flag_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stsClr && !hit) |=> !flag);
  // R12: an enabled carrier flips on every match
  a_r12_carrier_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (hit && carEn && !carWr) |=> (carState != $past(carState)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              carrierOut
);
  dpStrobe_t        strb;
  logic [CNT_W-1:0] cnt;
  logic             hit;

  cmp_timer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cnt(cnt), .hit(hit),
    .strb(strb), .irqOut(irqOut), .carrierOut(carrierOut)
  );

  cmp_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .hit(hit)
  );
endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, carrierOut;
  int          checks = 0, errors = 0;
  logic [31:0] rv;

  localparam logic [4:0] A_CTL = 5'h00, A_CMP = 5'h04, A_STS = 5'h08,
                         A_CNT = 5'h0C, A_CAR = 5'h10;
  localparam logic [31:0] F_RST = 32'h0400_0000, F_EN = 32'h4000_0000,
                          F_IE  = 32'h2000_0000, M_ONE = 32'h0,
                          M_PER = 32'h0800_0000, M_RSV = 32'h1000_0000,
                          M_CON = 32'h1800_0000;

  cmp_timer u_dut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .carrierOut(carrierOut));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a negedge; captured at the next posedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic stopAll();
    wr(A_CTL, F_RST); wr(A_STS, 32'h1); wr(A_CAR, 32'h0);
  endtask

  task automatic tReset();
    rd(A_CTL, rv); chk("R1 ctl", rv, 0);
    rd(A_CMP, rv); chk("R1 cmp", rv, 0);
    rd(A_STS, rv); chk("R1 sts", rv, 0);
    rd(A_CNT, rv); chk("R1 cnt", rv, 0);
    rd(A_CAR, rv); chk("R1 car", rv, 0);
    chk("R1 irq", irqOut, 0); chk("R1 carrier", carrierOut, 0);
  endtask

  task automatic tRegMap();
    wr(A_CTL, 32'h38F0_FFAB); rd(A_CTL, rv); chk("R2 ctl fields", rv, 32'h3800_00AB);
    wr(A_CMP, 32'hFFFF_1234); rd(A_CMP, rv); chk("R2 cmp", rv, 32'h1234);
    wr(A_CAR, 32'hFFFF_FFFC); rd(A_CAR, rv); chk("R2 car", rv, 32'h0);
    rd(5'h14, rv); chk("R2 unmapped", rv, 0);
    stopAll();
  endtask

  task automatic tPeriodic();
    stopAll();
    wr(A_CMP, 3);
    wr(A_CTL, F_EN | F_IE | M_PER | 32'd2);
    repeat (11) @(negedge clk);
    chk("R3 no irq before match", irqOut, 0);
    rd(A_CNT, rv); chk("R3 cnt at compare", rv, 3);
    @(negedge clk);
    chk("R3 irq at match", irqOut, 1);
    rd(A_CNT, rv); chk("R5 cnt back to 0", rv, 0);
    wr(A_STS, 1);
    repeat (10) @(negedge clk);
    rd(A_STS, rv); chk("R5 flag clear before 2nd", rv, 0);
    @(negedge clk);
    rd(A_STS, rv); chk("R5 flag on 2nd match", rv, 1);
  endtask

  task automatic tOneShot();
    stopAll();
    wr(A_CMP, 4);
    wr(A_CTL, F_EN | M_ONE);
    repeat (5) @(negedge clk);
    rd(A_STS, rv); chk("R4 flag", rv, 1);
    rd(A_CTL, rv); chk("R4 enable cleared", rv, 32'h0);
    repeat (10) @(negedge clk);
    rd(A_CNT, rv); chk("R4 cnt stays 0", rv, 0);
    wr(A_STS, 1); repeat (10) @(negedge clk);
    rd(A_STS, rv); chk("R4 no second flag", rv, 0);
  endtask

  task automatic tContinuous();
    stopAll();
    wr(A_CMP, 3);
    wr(A_CTL, F_EN | M_CON);
    repeat (4) @(negedge clk);
    rd(A_STS, rv); chk("R6 flag", rv, 1);
    rd(A_CNT, rv); chk("R6 counts past cmp", rv, 4);
    repeat (65531) @(negedge clk);
    rd(A_CNT, rv); chk("R6 cnt at max", rv, 32'hFFFF);
    @(negedge clk);
    rd(A_CNT, rv); chk("R6 wrap to 0", rv, 0);
  endtask

  task automatic tReserved();
    stopAll();
    wr(A_CMP, 3);
    wr(A_CTL, F_EN | M_RSV);
    repeat (20) @(negedge clk);
    rd(A_CNT, rv); chk("R7 cnt holds", rv, 0);
    rd(A_CTL, rv); chk("R7 active low", rv[25], 0);
  endtask

  task automatic tRestart();
    stopAll();
    wr(A_CMP, 100);
    wr(A_CTL, F_EN | M_PER);
    rd(A_CTL, rv); chk("R13 active reads 1", rv[25], 1);
    repeat (20) @(negedge clk);
    rd(A_CNT, rv); chk("R8 running count", rv, 20);
    wr(A_CMP, 50);
    rd(A_CNT, rv); chk("R8 cmp write restarts", rv, 0);
    repeat (5) @(negedge clk);
    rd(A_CNT, rv); chk("R8 counting after restart", rv, 5);
    wr(A_CNT, 32'h0000_1234);
    rd(A_CNT, rv); chk("R13 cnt write ignored", rv, 6);
    wr(A_CTL, F_EN | M_PER);
    rd(A_CNT, rv); chk("R8 ctl write restarts", rv, 0);
    wr(A_CTL, F_RST | F_EN | M_PER);
    rd(A_CTL, rv); chk("R9 reset bit clears enable", rv, M_PER);
    repeat (10) @(negedge clk);
    rd(A_CNT, rv); chk("R9 cnt stays 0", rv, 0);
    wr(A_CTL, 32'h0200_0000);
    rd(A_CTL, rv); chk("R13 active write ignored", rv, 0);
  endtask

  task automatic tFlagClear();
    stopAll();
    wr(A_CMP, 5);
    wr(A_CTL, F_EN | M_PER);
    repeat (5) @(negedge clk);
    rd(A_STS, rv); chk("R10 flag low before match", rv, 0);
    wr(A_STS, 1);
    rd(A_STS, rv); chk("R10 match beats clear", rv, 1);
    wr(A_STS, 0);
    rd(A_STS, rv); chk("R10 write 0 no effect", rv, 1);
    wr(A_STS, 1);
    rd(A_STS, rv); chk("R10 write 1 clears", rv, 0);
  endtask

  task automatic tIrq();
    stopAll();
    wr(A_CMP, 3);
    wr(A_CTL, F_EN | M_PER);
    repeat (4) @(negedge clk);
    rd(A_STS, rv); chk("R11 flag set", rv, 1);
    chk("R11 irq masked", irqOut, 0);
    wr(A_CTL, F_IE);
    chk("R11 irq when enabled", irqOut, 1);
    wr(A_STS, 1);
    chk("R11 irq drops on clear", irqOut, 0);
  endtask

  task automatic tCarrier();
    stopAll();
    wr(A_CAR, 1); chk("R12 idle high", carrierOut, 1);
    wr(A_CAR, 0); chk("R12 idle low", carrierOut, 0);
    wr(A_CAR, 2);
    wr(A_CMP, 3);
    wr(A_CTL, F_EN | M_PER);
    repeat (3) @(negedge clk);
    chk("R12 before first match", carrierOut, 0);
    @(negedge clk);
    chk("R12 toggle 1", carrierOut, 1);
    repeat (4) @(negedge clk);
    chk("R12 toggle 2", carrierOut, 0);
    wr(A_CAR, 1);
    repeat (10) @(negedge clk);
    chk("R12 disabled holds idle", carrierOut, 1);
    rd(A_CAR, rv); chk("R12 readback", rv, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegMap();
    tPeriodic();
    tOneShot();
    tContinuous();
    tReserved();
    tRestart();
    tFlagClear();
    tIrq();
    tCarrier();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule